// File: doc/BRIEF.md
# Byte and Halfword Lane Unit

This unit sits in the execute stage of a 32-bit integer datapath and handles the sub-word moves between registers. It either pulls one byte or one halfword out of a source register and returns it zero-extended, or writes the low byte or halfword of a source register into one lane of a destination value and leaves the other lanes as they were. The lane is not given by an immediate. It comes from the low bits of a byte address held in a third register, so code that walks a string or a packed array can reuse its pointer directly as the lane selector.

The issuing stage supplies a 2-bit operation, the three operand values and the three register field numbers. The field numbers are needed only to detect the zero-register conventions. The unit returns the new destination value, a register write enable, a flag write enable with the N and Z flags, and an illegal-operation marker. A valid/ready handshake with one output register gives one cycle of latency and full throughput.

Top module: `bhl_lane_unit`

## Requirements
- R1: The operation code selects the function: 2'b11 inserts a byte, 2'b10 inserts a halfword, 2'b01 extracts a byte and 2'b00 extracts a halfword.
- R2: The byte lane is address bits [1:0], with lane 0 at result bits 7:0 (little-endian). The halfword lane is address bit 1, with lane 0 at bits 15:0, and address bit 0 has no effect on a halfword operation.
- R3: An insert replaces only the addressed lane of the destination value with the low byte or low halfword of the source value, keeps every other destination bit, and asserts the register write enable.
- R4: An extract returns the addressed byte or halfword of the source value in the low bits of the result, with all upper bits zero.
- R5: When the selector field number is 0, the address is taken as 0 (lane 0) and the address value input is ignored.
- R6: For an insert whose source field number is 0, the inserted data is zero, so the addressed lane is cleared whatever the source value input holds.
- R7: For an extract whose destination field number is 0, the register write enable is low but the flag write enable is still high with valid flags.
- R8: A legal extract asserts the flag write enable, with N equal to the top bit of the extracted field and Z high when the field is zero. The V and C flags are written as zero. An insert keeps the flag write enable, N and Z low.
- R9: An insert with destination field 0, or an extract with source field 0, is illegal. It raises the illegal output and returns a zero result with both write enables low.
- R10: After reset, out_valid is low and in_ready is high. in_ready equals (!out_valid || out_ready). The result of an accepted operation is presented on the cycle after it is accepted and is held unchanged until it is taken. Results leave in the order they were accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation request valid |
| in_ready | output | 1 | Unit can accept an operation |
| in_op | input | 2 | Operation code (R1) |
| in_dst_val | input | 32 | Current destination register value |
| in_src_val | input | 32 | Source register value |
| in_adr_val | input | 32 | Lane-selector register value (byte address) |
| in_dst_fld | input | 4 | Destination register field number |
| in_src_fld | input | 4 | Source register field number |
| in_sel_fld | input | 4 | Lane-selector register field number |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 32 | New destination value |
| out_wr_en | output | 1 | Write the result to the destination register |
| out_flag_en | output | 1 | Update the condition flags (V and C cleared) |
| out_flag_n | output | 1 | Negative flag |
| out_flag_z | output | 1 | Zero flag |
| out_illegal | output | 1 | Illegal field combination, nothing written |

## Verification
The accept of a new operation and the hand-off of the previous result can land on the same clock edge. When they do, the output register has to drop the old result and load the new one at the same time, without losing or repeating an item. The bench provokes this by keeping in_valid high back to back while a pseudo-random pattern drives out_ready, so plain drains, stalls and simultaneous accept-and-drain edges are all mixed together. A scoreboard compares each result against a model computed from the requirements, in order, and the bound checker confirms that a stalled result holds steady.

// File: rtl/bhl_pkg.sv
package bhl_pkg;

   typedef enum logic [1:0] {
      LN_EXT_HALF = 2'b00,
      LN_EXT_BYTE = 2'b01,
      LN_INS_HALF = 2'b10,
      LN_INS_BYTE = 2'b11
   } lane_op_e;

   function automatic logic op_is_insert(input lane_op_e op);
      return op[1];
   endfunction

   function automatic logic op_is_byte(input lane_op_e op);
      return op[0];
   endfunction

endpackage

// File: rtl/bhl_lane_decode.sv
module bhl_lane_decode
   import bhl_pkg::*;
#(
   parameter int FLD_W  = 4,
   parameter int BIDX_W = 2
) (
   input  lane_op_e            op,
   input  logic [BIDX_W-1:0]   adr_lo,
   input  logic [FLD_W-1:0]    dst_fld,
   input  logic [FLD_W-1:0]    src_fld,
   input  logic [FLD_W-1:0]    sel_fld,
   output logic [BIDX_W-1:0]   byte_idx,
   output logic [BIDX_W-2:0]   half_idx,
   output logic                is_ins,
   output logic                is_byte,
   output logic                src_zero,
   output logic                legal,
   output logic                wr_en,
   output logic                flag_en
);

   logic [BIDX_W-1:0] eff_adr;
   logic              dst_is_zero;
   logic              src_is_zero;

   always_comb begin
      eff_adr     = (sel_fld == '0) ? '0 : adr_lo;
      dst_is_zero = (dst_fld == '0);
      src_is_zero = (src_fld == '0);
      is_ins      = op_is_insert(op);
      is_byte     = op_is_byte(op);
      byte_idx    = eff_adr;
      half_idx    = eff_adr[BIDX_W-1:1];
      src_zero    = src_is_zero;
      legal       = is_ins ? !dst_is_zero : !src_is_zero;
      wr_en       = legal && (is_ins || !dst_is_zero);
      flag_en     = legal && !is_ins;
   end

endmodule

// File: rtl/bhl_insert.sv
module bhl_insert #(
   parameter int DATA_W = 32,
   parameter int BYTE_W = 8,
   localparam int LANES  = DATA_W / BYTE_W,
   localparam int BIDX_W = $clog2(LANES),
   localparam int HALF_W = 2 * BYTE_W
) (
   input  logic [DATA_W-1:0] dst_val,
   input  logic [HALF_W-1:0] src_lo,
   input  logic              src_zero,
   input  logic              is_byte,
   input  logic [BIDX_W-1:0] byte_idx,
   input  logic [BIDX_W-2:0] half_idx,
   output logic [DATA_W-1:0] result
);

   logic [HALF_W-1:0] ins_data;
   assign ins_data = src_zero ? '0 : src_lo;

   for (genvar b = 0; b < LANES; b++) begin : g_lane
      logic              hit;
      logic [BYTE_W-1:0] new_bits;
      always_comb begin
         hit      = is_byte ? (byte_idx == BIDX_W'(b))
                            : (half_idx == (BIDX_W-1)'(b / 2));
         new_bits = is_byte ? ins_data[BYTE_W-1:0]
                            : ins_data[(b % 2)*BYTE_W +: BYTE_W];
      end
      assign result[b*BYTE_W +: BYTE_W] = hit ? new_bits
                                              : dst_val[b*BYTE_W +: BYTE_W];
   end

endmodule

// File: rtl/bhl_extract.sv
module bhl_extract #(
   parameter int DATA_W = 32,
   parameter int BYTE_W = 8,
   localparam int LANES  = DATA_W / BYTE_W,
   localparam int HLANES = LANES / 2,
   localparam int BIDX_W = $clog2(LANES),
   localparam int HALF_W = 2 * BYTE_W
) (
   input  logic [DATA_W-1:0] src_val,
   input  logic              is_byte,
   input  logic [BIDX_W-1:0] byte_idx,
   input  logic [BIDX_W-2:0] half_idx,
   output logic [DATA_W-1:0] field,
   output logic              neg,
   output logic              zero
);

   logic [BYTE_W-1:0] blane [LANES];
   logic [HALF_W-1:0] hlane [HLANES];

   for (genvar b = 0; b < LANES; b++) begin : g_blane
      assign blane[b] = src_val[b*BYTE_W +: BYTE_W];
   end
   for (genvar h = 0; h < HLANES; h++) begin : g_hlane
      assign hlane[h] = src_val[h*HALF_W +: HALF_W];
   end

   logic [BYTE_W-1:0] bsel;
   logic [HALF_W-1:0] hsel;

   always_comb begin
      bsel = blane[byte_idx];
      hsel = hlane[half_idx];
      if (is_byte) begin
         field = DATA_W'(bsel);
         neg   = bsel[BYTE_W-1];
         zero  = (bsel == '0);
      end else begin
         field = DATA_W'(hsel);
         neg   = hsel[HALF_W-1];
         zero  = (hsel == '0);
      end
   end

endmodule

// File: rtl/bhl_lane_unit.sv
module bhl_lane_unit
   import bhl_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int BYTE_W = 8,
   parameter int FLD_W  = 4,
   localparam int LANES  = DATA_W / BYTE_W,
   localparam int BIDX_W = $clog2(LANES),
   localparam int HALF_W = 2 * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [1:0]        in_op,
   input  logic [DATA_W-1:0] in_dst_val,
   input  logic [DATA_W-1:0] in_src_val,
   input  logic [DATA_W-1:0] in_adr_val,
   input  logic [FLD_W-1:0]  in_dst_fld,
   input  logic [FLD_W-1:0]  in_src_fld,
   input  logic [FLD_W-1:0]  in_sel_fld,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [DATA_W-1:0] out_result,
   output logic              out_wr_en,
   output logic              out_flag_en,
   output logic              out_flag_n,
   output logic              out_flag_z,
   output logic              out_illegal
);

   if (DATA_W % BYTE_W != 0) begin : g_bad_width
      $error("DATA_W must be a whole number of bytes");
   end
   if (LANES < 4 || (LANES & (LANES - 1)) != 0) begin : g_bad_lanes
      $error("lane count must be a power of two of at least four");
   end
   if (FLD_W < 1) begin : g_bad_fld
      $error("FLD_W must be positive");
   end

   logic [BIDX_W-1:0] byte_idx;
   logic [BIDX_W-2:0] half_idx;
   logic              is_ins;
   logic              is_byte;
   logic              src_zero;
   logic              legal;
   logic              wr_en_c;
   logic              flag_en_c;
   logic [DATA_W-1:0] ins_res;
   logic [DATA_W-1:0] ext_res;
   logic              ext_neg;
   logic              ext_zero;

   bhl_lane_decode #(
      .FLD_W  (FLD_W),
      .BIDX_W (BIDX_W)
   ) u_decode (
      .op       (lane_op_e'(in_op)),
      .adr_lo   (in_adr_val[BIDX_W-1:0]),
      .dst_fld  (in_dst_fld),
      .src_fld  (in_src_fld),
      .sel_fld  (in_sel_fld),
      .byte_idx (byte_idx),
      .half_idx (half_idx),
      .is_ins   (is_ins),
      .is_byte  (is_byte),
      .src_zero (src_zero),
      .legal    (legal),
      .wr_en    (wr_en_c),
      .flag_en  (flag_en_c)
   );

   bhl_insert #(
      .DATA_W (DATA_W),
      .BYTE_W (BYTE_W)
   ) u_insert (
      .dst_val  (in_dst_val),
      .src_lo   (in_src_val[HALF_W-1:0]),
      .src_zero (src_zero),
      .is_byte  (is_byte),
      .byte_idx (byte_idx),
      .half_idx (half_idx),
      .result   (ins_res)
   );

   bhl_extract #(
      .DATA_W (DATA_W),
      .BYTE_W (BYTE_W)
   ) u_extract (
      .src_val  (in_src_val),
      .is_byte  (is_byte),
      .byte_idx (byte_idx),
      .half_idx (half_idx),
      .field    (ext_res),
      .neg      (ext_neg),
      .zero     (ext_zero)
   );

   logic [DATA_W-1:0] nxt_result;
   logic              nxt_n;
   logic              nxt_z;

   always_comb begin
      nxt_result = '0;
      nxt_n      = 1'b0;
      nxt_z      = 1'b0;
      if (legal) begin
         nxt_result = is_ins ? ins_res : ext_res;
         nxt_n      = flag_en_c && ext_neg;
         nxt_z      = flag_en_c && ext_zero;
      end
   end

   logic accept;
   assign in_ready = !out_valid || out_ready;
   assign accept   = in_valid && in_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         out_result  <= '0;
         out_wr_en   <= 1'b0;
         out_flag_en <= 1'b0;
         out_flag_n  <= 1'b0;
         out_flag_z  <= 1'b0;
         out_illegal <= 1'b0;
      end else if (accept) begin
         out_valid   <= 1'b1;
         out_result  <= nxt_result;
         out_wr_en   <= wr_en_c;
         out_flag_en <= flag_en_c;
         out_flag_n  <= nxt_n;
         out_flag_z  <= nxt_z;
         out_illegal <= !legal;
      end else if (out_ready) begin
         out_valid   <= 1'b0;
      end
   end

endmodule

// File: rtl/bhl_lane_unit_chk.sv
module bhl_lane_unit_chk #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_ready,
   input logic              out_valid,
   input logic              out_ready,
   input logic [DATA_W-1:0] out_result,
   input logic              out_wr_en,
   input logic              out_flag_en,
   input logic              out_flag_n,
   input logic              out_flag_z,
   input logic              out_illegal
);

   // R10
   ready_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> in_ready);

   // R10
   accept_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> out_valid);

   // R10
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_result)
                                     && $stable(out_wr_en) && $stable(out_flag_en)));

   // R9
   illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_illegal) |-> (!out_wr_en && !out_flag_en && out_result == '0));

   // R4
   extract_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_flag_en) |-> (out_result[DATA_W-1:16] == '0));

   // R8
   zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_flag_en && out_flag_z) |-> (out_result == '0 && !out_flag_n));

   // R8
   insert_noflag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_flag_en) |-> (!out_flag_n && !out_flag_z));

endmodule

bind bhl_lane_unit bhl_lane_unit_chk #(.DATA_W(DATA_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_valid    (in_valid),
   .in_ready    (in_ready),
   .out_valid   (out_valid),
   .out_ready   (out_ready),
   .out_result  (out_result),
   .out_wr_en   (out_wr_en),
   .out_flag_en (out_flag_en),
   .out_flag_n  (out_flag_n),
   .out_flag_z  (out_flag_z),
   .out_illegal (out_illegal)
);

// File: tb/bhl_lane_unit_tb.sv
`timescale 1ns/1ps
module bhl_lane_unit_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [1:0]  in_op = '0;
   logic [31:0] in_dst_val = '0;
   logic [31:0] in_src_val = '0;
   logic [31:0] in_adr_val = '0;
   logic [3:0]  in_dst_fld = '0;
   logic [3:0]  in_src_fld = '0;
   logic [3:0]  in_sel_fld = '0;
   logic        out_valid;
   logic        out_ready = 1'b1;
   logic [31:0] out_result;
   logic        out_wr_en;
   logic        out_flag_en;
   logic        out_flag_n;
   logic        out_flag_z;
   logic        out_illegal;

   always #2 clk = ~clk;

   bhl_lane_unit u_dut (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op),
      .in_dst_val(in_dst_val), .in_src_val(in_src_val), .in_adr_val(in_adr_val),
      .in_dst_fld(in_dst_fld), .in_src_fld(in_src_fld), .in_sel_fld(in_sel_fld),
      .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
      .out_wr_en(out_wr_en), .out_flag_en(out_flag_en), .out_flag_n(out_flag_n),
      .out_flag_z(out_flag_z), .out_illegal(out_illegal)
   );

   typedef struct {
      logic [31:0] res;
      logic        wr;
      logic        fe;
      logic        n;
      logic        z;
      logic        ill;
      string       tag;
   } exp_t;

   exp_t exp_q[$];
   int   n_cmp = 0;
   int   n_bad = 0;
   bit   bp_mode = 1'b0;
   bit   done = 1'b0;
   bit   summary_done = 1'b0;
   logic [15:0] lfsr = 16'hACE1;

   function automatic exp_t model(input logic [1:0] op, input logic [31:0] d, s, a,
                                  input logic [3:0] df, sf, lf, input string tag);
      exp_t e;
      logic [31:0] adr;
      logic [31:0] sv;
      logic [1:0]  bi;
      logic        hi;
      e.tag = tag; e.res = '0; e.wr = 0; e.fe = 0; e.n = 0; e.z = 0; e.ill = 0;
      adr = (lf == 0) ? 32'd0 : a;   // R5
      bi  = adr[1:0];                // R2
      hi  = adr[1];
      if (op[1] ? (df == 0) : (sf == 0)) begin   // R9
         e.ill = 1;
         return e;
      end
      if (op[1]) begin               // R3, R6
         sv = (sf == 0) ? 32'd0 : s;
         e.res = d;
         if (op[0]) e.res[bi*8 +: 8]  = sv[7:0];
         else       e.res[hi*16 +: 16] = sv[15:0];
         e.wr = 1;
      end else begin                 // R4, R7, R8
         if (op[0]) begin
            e.res = {24'd0, s[bi*8 +: 8]};
            e.n   = e.res[7];
         end else begin
            e.res = {16'd0, s[hi*16 +: 16]};
            e.n   = e.res[15];
         end
         e.z  = (e.res == 0);
         e.wr = (df != 0);
         e.fe = 1;
      end
      return e;
   endfunction

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic send(input logic [1:0] op, input logic [31:0] d, s, a,
                       input logic [3:0] df, sf, lf, input string tag);
      @(negedge clk);
      in_valid = 1; in_op = op; in_dst_val = d; in_src_val = s; in_adr_val = a;
      in_dst_fld = df; in_src_fld = sf; in_sel_fld = lf;
      #1;
      while (!in_ready) begin
         @(negedge clk);
         #1;
      end
      exp_q.push_back(model(op, d, s, a, df, sf, lf, tag));
      @(posedge clk);
   endtask

   // monitor: pops expected items as results are handed off
   initial begin
      forever begin
         @(negedge clk);
         if (bp_mode) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            out_ready = lfsr[0] | lfsr[3];
         end else begin
            out_ready = 1'b1;
         end
         #1;
         if (rst_n && out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
               check(0, "R10", "unexpected result", out_result, 32'd0);
            end else begin
               exp_t e;
               e = exp_q.pop_front();
               check(out_result == e.res, e.tag, "result", out_result, e.res);
               check(out_wr_en == e.wr, e.tag, "wr_en", 32'(out_wr_en), 32'(e.wr));
               check(out_flag_en == e.fe && out_flag_n == e.n && out_flag_z == e.z,
                     e.tag, "flags{en,n,z}", {29'd0, out_flag_en, out_flag_n, out_flag_z},
                     {29'd0, e.fe, e.n, e.z});
               check(out_illegal == e.ill, e.tag, "illegal", 32'(out_illegal), 32'(e.ill));
            end
         end
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!summary_done) begin
         n_cmp++; n_bad++;
         $display("FAIL R10 watchdog: actual hung expected done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10 reset state
      check(out_valid == 0, "R10", "reset out_valid", 32'(out_valid), 32'd0);
      check(in_ready == 1, "R10", "reset in_ready", 32'(in_ready), 32'd1);
      rst_n = 1;
      @(negedge clk);
      check(out_valid == 0 && out_illegal == 0, "R10", "idle after reset",
            {30'd0, out_valid, out_illegal}, 32'd0);

      // R1/R2 byte extract each lane
      for (int i = 0; i < 4; i++)
         send(2'b01, 32'h0, 32'h80FF_1200 | 32'h0000_0034, 32'(i), 4'd3, 4'd5, 4'd6, "R2");
      // R1/R2 halfword extract, bit 0 ignored
      for (int i = 0; i < 4; i++)
         send(2'b00, 32'h0, 32'h9ABC_0012, 32'(i) + 32'h100, 4'd3, 4'd5, 4'd6, "R2");
      // R3 byte insert each lane, R1
      for (int i = 0; i < 4; i++)
         send(2'b11, 32'h1122_3344, 32'hDEAD_BEA5, 32'(i), 4'd2, 4'd5, 4'd6, "R3");
      // R3 halfword insert both lanes
      send(2'b10, 32'h1122_3344, 32'hDEAD_BEA5, 32'd2, 4'd2, 4'd5, 4'd6, "R3");
      send(2'b10, 32'h1122_3344, 32'hDEAD_BEA5, 32'd1, 4'd2, 4'd5, 4'd6, "R1");
      // R4 zero extension of top-bit-set values
      send(2'b01, 32'h0, 32'hFFFF_FFFF, 32'd3, 4'd1, 4'd2, 4'd3, "R4");
      send(2'b00, 32'h0, 32'hFFFF_FFFF, 32'd2, 4'd1, 4'd2, 4'd3, "R4");
      // R5 selector field zero forces lane 0
      send(2'b01, 32'h0, 32'hAA00_00BB, 32'd3, 4'd1, 4'd2, 4'd0, "R5");
      send(2'b11, 32'hFFFF_FFFF, 32'h0000_0012, 32'd3, 4'd1, 4'd2, 4'd0, "R5");
      // R6 insert with source field zero clears the lane
      send(2'b11, 32'hFFFF_FFFF, 32'h0000_0077, 32'd1, 4'd1, 4'd0, 4'd3, "R6");
      send(2'b10, 32'hFFFF_FFFF, 32'h0000_7777, 32'd2, 4'd1, 4'd0, 4'd3, "R6");
      // R7 extract with destination field zero
      send(2'b01, 32'h0, 32'h0000_8000, 32'd1, 4'd0, 4'd2, 4'd3, "R7");
      send(2'b00, 32'h0, 32'h0000_0000, 32'd0, 4'd0, 4'd2, 4'd3, "R7");
      // R8 flag cases
      send(2'b01, 32'h0, 32'h0000_0000, 32'd2, 4'd1, 4'd2, 4'd3, "R8");
      send(2'b00, 32'h0, 32'h7FFF_0000, 32'd2, 4'd1, 4'd2, 4'd3, "R8");
      send(2'b11, 32'h0, 32'h0000_0000, 32'd0, 4'd1, 4'd2, 4'd3, "R8");
      // R9 illegal combinations
      send(2'b11, 32'h1234_5678, 32'h55, 32'd0, 4'd0, 4'd2, 4'd3, "R9");
      send(2'b10, 32'h1234_5678, 32'h55, 32'd0, 4'd0, 4'd0, 4'd3, "R9");
      send(2'b01, 32'h1234_5678, 32'h55, 32'd0, 4'd1, 4'd0, 4'd3, "R9");
      send(2'b00, 32'h1234_5678, 32'h55, 32'd0, 4'd0, 4'd0, 4'd0, "R9");

      // R10 back-pressure: accept and hand-off on the same edge, mixed with stalls
      bp_mode = 1'b1;
      for (int i = 0; i < 300; i++) begin
         logic [31:0] rd, rs, ra;
         logic [3:0]  df, sf, lf;
         logic [1:0]  op;
         rd = $urandom; rs = $urandom; ra = $urandom;
         op = 2'($urandom);
         df = ($urandom % 6 == 0) ? 4'd0 : 4'($urandom);
         sf = ($urandom % 6 == 0) ? 4'd0 : 4'($urandom);
         lf = ($urandom % 6 == 0) ? 4'd0 : 4'($urandom);
         send(op, rd, rs, ra, df, sf, lf, "R10");
      end
      @(negedge clk);
      in_valid = 0;
      bp_mode = 1'b0;
      repeat (20) @(negedge clk);
      check(exp_q.size() == 0, "R10", "results drained", 32'(exp_q.size()), 32'd0);
      done = 1'b1;
      summary_done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule